// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block lets a host run single operations on a small three-wire serial EEPROM that holds 64 words of 16 bits. The host loads a data register and then writes a command (operation code plus word address). The controller raises `busy`, produces the whole serial exchange on chip select, serial clock and data-to-memory, and samples the data line coming back from the memory. It supports read, write, erase, erase/write enable and erase/write disable. For a read, the result appears on `data_out` in the same cycle that `busy` falls. For write and erase, the controller waits for the memory's ready indication before it clears `busy`. If that indication does not arrive within a programmable number of system clock cycles, the operation ends and `timed_out` is set.

The serial clock runs at a fraction of the system clock. Each half period lasts `SK_HALF` system cycles. The default of `TIMEOUT_CYC` gives 30 ms at 125 MHz. A disable input hands the serial clock and data pins to two host-programmed output levels and holds chip select low.

Command and data writes are plain one-cycle register strobes, not a stream. There is no back-pressure: a strobe that arrives while the engine cannot take it is dropped. The host learns that the engine is free by polling `busy`.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: After reset `busy`, `timed_out`, `ee_cs`, `ee_sk` and `ee_di` are 0 and `data_out` is 0.
- R2: Each transaction raises `ee_cs` and then sends a start bit of 1, a 2-bit wire code and the 6-bit address, MSB first. The wire codes are read 10, write 01, erase 11, enable 00 with address 11xxxx, and disable 00 with address 00xxxx. `ee_di` changes only while `ee_sk` is low, `ee_do` is sampled as `ee_sk` rises, and each level of `ee_sk` lasts `SK_HALF` system cycles.
- R3: Host code 0 (read) clocks past the dummy 0 bit and captures 16 bits, MSB first. The captured word is on `data_out` when `busy` falls.
- R4: Host code 1 (write) sends the 16-bit data register MSB first after the address. The controller then drops `ee_cs` for one serial clock period, raises it again and waits for `ee_do` high before it clears `busy`.
- R5: Host code 3 sends erase/write enable and host code 4 sends erase/write disable. A write or erase has effect in the memory only after an enable.
- R6: Host code 2 (erase) sends the address only and then performs the same ready wait as a write. A read of the erased word afterwards returns 16'hFFFF.
- R7: If ready does not arrive within `TIMEOUT_CYC` cycles, `timed_out` rises in the same cycle that `busy` falls. Any accepted command clears `timed_out`.
- R8: `cmd_wr` and `data_wr` are ignored while `busy` is 1. `busy` rises only on an accepted command.
- R9: While `if_disable` is 1, `ee_sk` follows `gpo_clk`, `ee_di` follows `gpo_dat`, `ee_cs` is 0, and commands are ignored.
- R10: Host codes 5 to 7 are ignored: `busy` and `ee_cs` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Host code: 0 read, 1 write, 2 erase, 3 enable, 4 disable |
| cmd_addr | input | 6 | Word address |
| data_wr | input | 1 | One-cycle strobe that loads the data register |
| data_in | input | 16 | Value for the data register |
| data_out | output | 16 | Data register contents (read results) |
| busy | output | 1 | Operation in progress |
| timed_out | output | 1 | Last write/erase got no ready indication in time |
| if_disable | input | 1 | Hands the pins to the general-purpose levels |
| gpo_clk | input | 1 | Level for the serial clock pin while disabled |
| gpo_dat | input | 1 | Level for the data pin while disabled |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready from the memory |

## Verification
The bench runs reads at two addresses whose words have different bit patterns, so that a swapped, shifted or misaligned capture shows up as a wrong value. A write of a new value followed by an erase at the same address separates the write path from the erase path. A write or erase issued before enable, or after disable, must leave the old word readable, which shows whether the enable state is honoured. A memory model that never reports ready separates the timeout exit from the normal ready exit. Strobes issued during a busy operation, unused host codes and disabled-mode stimulus must each leave the pins and the data register untouched.

// File: rtl/uwe_pkg.sv
package uwe_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_EWEN  = 3'd3,
    OP_EWDS  = 3'd4
  } host_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SHIFT,
    S_GAP,
    S_POLL,
    S_DONE
  } eng_state_e;

  // 2-bit code placed on the wire after the start bit
  function automatic logic [1:0] wire_code(host_op_e op);
    case (op)
      OP_READ:  wire_code = 2'b10;
      OP_WRITE: wire_code = 2'b01;
      OP_ERASE: wire_code = 2'b11;
      default:  wire_code = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/uwe_sk_tick.sv
module uwe_sk_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en || tick) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uwe_timeout.sv
module uwe_timeout #(
  parameter int LIMIT = 3_750_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  assign expired = (cnt == TW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)       cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uwe_serdes.sv
module uwe_serdes #(
  parameter int FRAME_W = 25,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               tx_shift,
  input  logic               rx_shift,
  input  logic               rx_bit,
  output logic               tx_msb,
  output logic [DATA_W-1:0]  rx_word
);
  logic [FRAME_W-1:0] tx_q;
  logic [DATA_W-1:0]  rx_q;

  assign tx_msb  = tx_q[FRAME_W-1];
  assign rx_word = rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        tx_q <= '0;
    else if (load)     tx_q <= frame;
    else if (tx_shift) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
  end

  // Every rising-edge sample shifts in; the last DATA_W samples are the word
  always_ff @(posedge clk) begin
    if (!rst_n)        rx_q <= '0;
    else if (rx_shift) rx_q <= {rx_q[DATA_W-2:0], rx_bit};
  end
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
  import uwe_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SK_HALF     = 4,
  parameter int TIMEOUT_CYC = 3_750_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              busy,
  output logic              timed_out,
  input  logic              if_disable,
  input  logic              gpo_clk,
  input  logic              gpo_dat,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [ADDR_W-1:0] EWEN_ADDR = {2'b11, {(ADDR_W-2){1'b0}}};

  eng_state_e        state;
  host_op_e          op_q;
  logic [CNT_W-1:0]  clk_cnt, clk_total;
  logic              sk_q, cs_q, busy_q, to_q;
  logic [1:0]        gap_cnt;
  logic [DATA_W-1:0] data_q;

  logic              tick, expired, tx_msb;
  logic [DATA_W-1:0] rx_word;
  logic              cmd_go;
  host_op_e          new_op;
  logic [ADDR_W-1:0] wire_addr;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]  new_total;

  assign new_op = host_op_e'(cmd_op);
  assign cmd_go = cmd_wr && (state == S_IDLE) && !if_disable && (cmd_op <= 3'd4);

  always_comb begin
    case (new_op)
      OP_EWEN: wire_addr = EWEN_ADDR;
      OP_EWDS: wire_addr = '0;
      default: wire_addr = cmd_addr;
    endcase
    frame = {1'b1, wire_code(new_op), wire_addr,
             (new_op == OP_WRITE) ? data_q : {DATA_W{1'b0}}};
    case (new_op)
      OP_READ:  new_total = CNT_W'(HDR_W + 1 + DATA_W);
      OP_WRITE: new_total = CNT_W'(FRAME_W);
      default:  new_total = CNT_W'(HDR_W);
    endcase
  end

  uwe_sk_tick #(.HALF(SK_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(state != S_IDLE), .tick(tick)
  );

  uwe_timeout #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(cmd_go),
    .run((state == S_GAP) || (state == S_POLL)), .expired(expired)
  );

  uwe_serdes #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_serdes (
    .clk(clk), .rst_n(rst_n), .load(cmd_go), .frame(frame),
    .tx_shift((state == S_SHIFT) && tick && sk_q),
    .rx_shift((state == S_SHIFT) && tick && !sk_q),
    .rx_bit(ee_do), .tx_msb(tx_msb), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= OP_READ;
      clk_cnt   <= '0;
      clk_total <= '0;
      sk_q      <= 1'b0;
      cs_q      <= 1'b0;
      busy_q    <= 1'b0;
      to_q      <= 1'b0;
      gap_cnt   <= '0;
      data_q    <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (cmd_go) begin
            op_q      <= new_op;
            clk_cnt   <= '0;
            clk_total <= new_total;
            cs_q      <= 1'b1;
            sk_q      <= 1'b0;
            busy_q    <= 1'b1;
            to_q      <= 1'b0;
            state     <= S_SHIFT;
          end else if (data_wr) begin
            data_q <= data_in;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            if (!sk_q) begin
              sk_q <= 1'b1;
            end else begin
              sk_q    <= 1'b0;
              clk_cnt <= clk_cnt + 1'b1;
              if (clk_cnt == clk_total - 1'b1) begin
                if (op_q == OP_WRITE || op_q == OP_ERASE) begin
                  cs_q    <= 1'b0;
                  gap_cnt <= '0;
                  state   <= S_GAP;
                end else begin
                  state <= S_DONE;
                end
              end
            end
          end
        end
        S_GAP, S_POLL: begin
          if (expired) begin
            cs_q   <= 1'b0;
            busy_q <= 1'b0;
            to_q   <= 1'b1;
            state  <= S_IDLE;
          end else if (tick) begin
            if (state == S_GAP) begin
              gap_cnt <= gap_cnt + 1'b1;
              if (gap_cnt == 2'd1) begin
                cs_q  <= 1'b1;
                state <= S_POLL;
              end
            end else if (ee_do) begin
              cs_q  <= 1'b0;
              state <= S_DONE;
            end
          end
        end
        S_DONE: begin
          cs_q   <= 1'b0;
          busy_q <= 1'b0;
          if (op_q == OP_READ) data_q <= rx_word;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign data_out  = data_q;
  assign busy      = busy_q;
  assign timed_out = to_q;
  assign ee_cs     = if_disable ? 1'b0    : cs_q;
  assign ee_sk     = if_disable ? gpo_clk : sk_q;
  assign ee_di     = if_disable ? gpo_dat : ((state == S_SHIFT) ? tx_msb : 1'b0);

endmodule

// File: rtl/uwe_checker.sv
module uwe_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_wr,
  input logic busy,
  input logic timed_out,
  input logic if_disable,
  input logic gpo_clk,
  input logic gpo_dat,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);
  // R8: busy starts only from a command strobe
  assert_busy_from_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr));

  // R7: an accepted command leaves the timeout flag clear
  assert_new_cmd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !timed_out);

  // R7: timeout flag appears exactly as busy ends
  assert_timeout_ends_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> $fell(busy));

  // R2: data to the memory moves only while the serial clock is low
  assert_di_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_disable && !$past(if_disable) && !$stable(ee_di)) |-> !ee_sk);

  // R2: serial clock only toggles with chip select high
  assert_sk_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_disable && !ee_cs) |-> !ee_sk);

  // R1: idle engine keeps chip select low
  assert_idle_cs_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !if_disable) |-> !ee_cs);

  // R9: pins follow the general-purpose levels while disabled
  assert_gpo_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    if_disable |-> (!ee_cs && ee_sk == gpo_clk && ee_di == gpo_dat));
endmodule

bind uwire_eeprom_ctrl uwe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .busy(busy),
  .timed_out(timed_out), .if_disable(if_disable), .gpo_clk(gpo_clk),
  .gpo_dat(gpo_dat), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/uwire_eeprom_ctrl_test.sv
`timescale 1ns/1ps
module uwire_eeprom_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [5:0]  cmd_addr = 6'd0;
  logic        data_wr = 1'b0;
  logic [15:0] data_in = 16'h0;
  logic [15:0] data_out;
  logic        busy, timed_out;
  logic        if_disable = 1'b0, gpo_clk = 1'b0, gpo_dat = 1'b0;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do;

  always #4 clk = ~clk;

  uwire_eeprom_ctrl #(.SK_HALF(4), .TIMEOUT_CYC(3000)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .data_wr(data_wr), .data_in(data_in),
    .data_out(data_out), .busy(busy), .timed_out(timed_out),
    .if_disable(if_disable), .gpo_clk(gpo_clk), .gpo_dat(gpo_dat),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int a);
    return 16'h1000 + 16'(a * 16'h0107);
  endfunction

  // ---------------- memory model ----------------
  logic [15:0] mem [64];
  int          bc = 0;
  logic [8:0]  mcmd = '0;
  logic [15:0] mwd = '0;
  logic        ewen = 0, rd_bit = 0, cs_p = 0, sk_p = 0, m_do = 0;
  int          mbusy = 0;
  bit          stuck = 0;
  assign ee_do = m_do;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] = init_word(i);
      bc = 0; mcmd = '0; mwd = '0; ewen = 0; rd_bit = 0;
      cs_p = 0; sk_p = 0; m_do = 0; mbusy = 0;
    end else begin
      if (ee_cs && !cs_p) begin bc = 0; mcmd = '0; mwd = '0; rd_bit = 0; end
      if (ee_cs && ee_sk && !sk_p) begin
        if (bc < 9) mcmd = {mcmd[7:0], ee_di};
        else if (bc < 25) mwd = {mwd[14:0], ee_di};
        bc++;
      end
      if (ee_cs && !ee_sk && sk_p && bc >= 9 && mcmd[7:6] == 2'b10)
        rd_bit = (bc >= 10 && bc <= 25) ? mem[mcmd[5:0]][25-bc] : 1'b0;
      if (!ee_cs && cs_p) begin
        if (bc >= 9 && mcmd[8]) begin
          case (mcmd[7:6])
            2'b00: if (mcmd[5:4] == 2'b11) ewen = 1; else if (mcmd[5:4] == 2'b00) ewen = 0;
            2'b01: if (bc == 25 && ewen) begin mem[mcmd[5:0]] = mwd; mbusy = 300; end
            2'b11: if (bc == 9 && ewen) begin mem[mcmd[5:0]] = 16'hFFFF; mbusy = 300; end
            default: ;
          endcase
        end
        bc = 0;
      end
      if (mbusy > 0 && !stuck) mbusy--;
      m_do = (ee_cs && bc >= 9 && mcmd[7:6] == 2'b10) ? rd_bit : (ee_cs ? (mbusy == 0) : 1'b0);
      cs_p = ee_cs; sk_p = ee_sk;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [15:0] d;
    bit          chk;
    bit          to;
    string       tag;
  } item_t;
  item_t sb[$];
  logic bprev = 0;

  always @(negedge clk) begin
    if (rst_n && bprev && !busy) begin
      if (sb.size() == 0) begin
        check(0, "R8 completion with no command", 32'(busy), 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(timed_out == it.to, {it.tag, " timeout flag"}, 32'(timed_out), 32'(it.to));
        if (it.chk) check(data_out == it.d, {it.tag, " data"}, 32'(data_out), 32'(it.d));
      end
    end
    bprev = busy;
  end

  task automatic issue(input logic [2:0] op, input logic [5:0] a);
    @(negedge clk); cmd_op = op; cmd_addr = a; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [2:0] op, input logic [5:0] a, input logic [15:0] exp,
                     input bit chk, input bit to, input string tag);
    item_t it;
    it.d = exp; it.chk = chk; it.to = to; it.tag = tag;
    sb.push_back(it);
    issue(op, a);
    wait_idle();
  endtask

  task automatic set_data(input logic [15:0] v);
    @(negedge clk); data_in = v; data_wr = 1;
    @(negedge clk); data_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!busy && !timed_out && !ee_cs && !ee_sk && !ee_di, "R1 pins after reset",
          {busy, timed_out, ee_cs, ee_sk, ee_di}, 0);
    check(data_out == 16'h0, "R1 data after reset", 32'(data_out), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 + R3: read, also measure one serial clock high level
    begin
      item_t it;
      int w;
      it.d = init_word(42); it.chk = 1; it.to = 0; it.tag = "R3 read 0x2A";
      sb.push_back(it);
      issue(3'd0, 6'd42);
      while (!ee_sk) @(negedge clk);
      w = 0;
      while (ee_sk) begin w++; @(negedge clk); end
      check(w == 4, "R2 serial clock high level", 32'(w), 4);
      wait_idle();
    end
    run(3'd0, 6'd1, init_word(1), 1, 0, "R3 read 0x01");

    // R5: write before enable has no effect
    set_data(16'hBEEF);
    run(3'd1, 6'd3, 16'h0, 0, 0, "R5 write while locked");
    run(3'd0, 6'd3, init_word(3), 1, 0, "R5 locked word unchanged");

    // R4: enable, write, read back
    run(3'd3, 6'd0, 16'h0, 0, 0, "R5 enable");
    set_data(16'hA5C3);
    run(3'd1, 6'd3, 16'h0, 0, 0, "R4 write");
    run(3'd0, 6'd3, 16'hA5C3, 1, 0, "R4 readback");

    // R6: erase
    run(3'd2, 6'd3, 16'h0, 0, 0, "R6 erase");
    run(3'd0, 6'd3, 16'hFFFF, 1, 0, "R6 erased word");
    set_data(16'h0000);
    run(3'd1, 6'd63, 16'h0, 0, 0, "R4 write top address");
    run(3'd0, 6'd63, 16'h0000, 1, 0, "R4 top address readback");

    // R5: disable, erase has no effect
    run(3'd4, 6'd0, 16'h0, 0, 0, "R5 disable");
    run(3'd2, 6'd63, 16'h0, 0, 0, "R5 erase while locked");
    run(3'd0, 6'd63, 16'h0000, 1, 0, "R5 word kept after locked erase");

    // R8: strobes during busy are dropped
    run(3'd3, 6'd0, 16'h0, 0, 0, "R8 enable");
    set_data(16'h5A5A);
    begin
      item_t it;
      it.d = 16'h5A5A; it.chk = 1; it.to = 0; it.tag = "R8 data kept during write";
      sb.push_back(it);
      issue(3'd1, 6'd9);
      repeat (20) @(negedge clk);
      data_in = 16'h7777; data_wr = 1; cmd_op = 3'd0; cmd_addr = 6'd9; cmd_wr = 1;
      @(negedge clk); data_wr = 0; cmd_wr = 0;
      wait_idle();
    end
    begin
      bit quiet = 1;
      for (int k = 0; k < 100; k++) begin
        if (busy || ee_cs) quiet = 0;
        @(negedge clk);
      end
      check(quiet, "R8 no restart after dropped command", 32'(quiet), 1);
    end
    run(3'd0, 6'd9, 16'h5A5A, 1, 0, "R8 written word readback");

    // R7: timeout, then clear by next command
    stuck = 1;
    run(3'd1, 6'd7, 16'h0, 0, 1, "R7 write never ready");
    stuck = 0;
    begin
      item_t it;
      it.d = 0; it.chk = 0; it.to = 0; it.tag = "R7 enable after timeout";
      sb.push_back(it);
      issue(3'd3, 6'd0);
      check(busy && !timed_out, "R7 flag cleared by new command", {busy, timed_out}, 2'b10);
      wait_idle();
    end

    // R10: unused host codes
    for (int c = 5; c < 8; c++) begin
      bit quiet = 1;
      issue(3'(c), 6'd0);
      for (int k = 0; k < 20; k++) begin
        if (busy || ee_cs) quiet = 0;
        @(negedge clk);
      end
      check(quiet, "R10 unused code ignored", 32'(c), 0);
    end

    // R9: general-purpose pin mode
    if_disable = 1; gpo_clk = 1; gpo_dat = 0;
    @(negedge clk);
    check(ee_sk && !ee_di && !ee_cs, "R9 pins 1/0", {ee_cs, ee_sk, ee_di}, 3'b010);
    gpo_clk = 0; gpo_dat = 1;
    @(negedge clk);
    check(!ee_sk && ee_di && !ee_cs, "R9 pins 0/1", {ee_cs, ee_sk, ee_di}, 3'b001);
    issue(3'd0, 6'd1);
    repeat (10) @(negedge clk);
    check(!busy, "R9 command ignored while disabled", 32'(busy), 0);
    if_disable = 0;
    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R8 scoreboard drained", 32'(sb.size()), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule